// File: doc/BRIEF.md
# Write-One-to-Clear Event Flag Bank

This block holds a small bank of sticky event flags for a timer, together with their per-source interrupt enables. Each hardware event (one counter overflow and two compare matches) arrives as a single-cycle pulse and latches its flag to 1. The flag stays at 1 until one of two things happens. Software can write a word to the flag address, and every 1 in that word clears the matching flag. The CPU can also acknowledge the matching interrupt vector, which clears that flag.

A bus write to the flag address never loads data into the flags. A 0 in the written word leaves its flag alone. Software can therefore clear exactly one flag by writing a word with only that bit set, and no read-modify-write is needed. Each source drives its own interrupt request. The request is active while the global enable input, the source's enable bit and the source's flag are all 1. Prioritising the requests and fetching the vector happen outside this block.

Top module: `irq_flag_bank`

## Requirements
- R1: After synchronous active-high reset, every flag and every enable bit is 0, and every interrupt request is 0.
- R2: An event pulse on source i sets flag i one clock later. In the flag word, bit 0 is the overflow flag, and bits 1 and 2 are the two compare-match flags.
- R3: A bus write to the flag address (0) clears every flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged.
- R4: An acknowledge pulse on source i clears flag i one clock later and leaves the other flags unchanged.
- R5: When an event and a clear (a write of 1, an acknowledge, or both) reach the same flag in the same cycle, the flag ends at 1.
- R6: Interrupt request i is combinationally equal to global enable AND enable bit i AND flag i.
- R7: The enable register at address 1 is read/write, with bit i enabling source i. Unused upper bits of both registers read as 0, and any other address reads 0.
- R8: Reads have no side effect. A write to one address never changes the register at the other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register address (0 = flags, 1 = enables) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register |
| evt_pulse | input | NUM_SRC | One-cycle hardware event per source |
| irq_ack | input | NUM_SRC | Vector acknowledge per source |
| glb_ie | input | 1 | Global interrupt enable |
| irq_req | output | NUM_SRC | Per-source interrupt request |

## Verification
The bench sweeps every starting flag pattern against every write mask, which separates a correct write-one-to-clear from a plain store, an inverted mask, and a write of 0 that wrongly clears. The same sweep is repeated with every acknowledge vector. It also runs with events, writes and acknowledges all colliding in one cycle, which shows whether the set or the clear takes priority. All 128 combinations of flags, enables and global enable are applied, so any missing term in the request gating is exposed. Enable writes carry junk in the upper bits, and the bench reads unmapped addresses, to confirm the address decode and that each register is isolated from the other.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

  parameter int unsigned IRQF_NUM_SRC = 3;
  parameter int unsigned IRQF_DATA_W  = 8;
  parameter int unsigned IRQF_ADDR_W  = 2;

  // Sticky flag update: a set event has priority over any clear.
  function automatic logic flag_next(input logic cur, input logic set_i,
                                     input logic clr_i);
    if (set_i)      return 1'b1;
    else if (clr_i) return 1'b0;
    else            return cur;
  endfunction

  // Request gating for one source.
  function automatic logic req_gate(input logic glb, input logic en,
                                    input logic flg);
    return glb & en & flg;
  endfunction

endpackage

// File: rtl/irqf_decode.sv
module irqf_decode #(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned FLAG_ADDR = 0,
  parameter int unsigned EN_ADDR   = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              flag_sel,
  output logic              en_sel,
  output logic              flag_wr,
  output logic              en_wr
);
  always_comb begin
    flag_sel = (addr == ADDR_W'(FLAG_ADDR));
    en_sel   = (addr == ADDR_W'(EN_ADDR));
    flag_wr  = wr & flag_sel;
    en_wr    = wr & en_sel;
  end
endmodule

// File: rtl/irqf_flag_cell.sv
module irqf_flag_cell
  import irq_flag_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr_sw,
  input  logic clr_ack,
  output logic q
);
  logic clr_any;
  assign clr_any = clr_sw | clr_ack;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= flag_next(q, set_evt, clr_any);
  end
endmodule

// File: rtl/irqf_enable_reg.sv
module irqf_enable_reg #(
  parameter int unsigned NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] en
);
  always_ff @(posedge clk) begin
    if (rst)     en <= '0;
    else if (we) en <= wdata;
  end
endmodule

// File: rtl/irqf_read_mux.sv
module irqf_read_mux #(
  parameter int unsigned NUM_SRC = 3,
  parameter int unsigned DATA_W  = 8
) (
  input  logic               flag_sel,
  input  logic               en_sel,
  input  logic [NUM_SRC-1:0] flags,
  input  logic [NUM_SRC-1:0] en,
  output logic [DATA_W-1:0]  rdata
);
  always_comb begin
    rdata = '0;
    if (flag_sel)    rdata[NUM_SRC-1:0] = flags;
    else if (en_sel) rdata[NUM_SRC-1:0] = en;
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_flag_pkg::*;
#(
  parameter int unsigned NUM_SRC   = IRQF_NUM_SRC,
  parameter int unsigned DATA_W    = IRQF_DATA_W,
  parameter int unsigned ADDR_W    = IRQF_ADDR_W,
  parameter int unsigned FLAG_ADDR = 0,
  parameter int unsigned EN_ADDR   = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] evt_pulse,
  input  logic [NUM_SRC-1:0] irq_ack,
  input  logic               glb_ie,
  output logic [NUM_SRC-1:0] irq_req
);
  localparam int unsigned SPARE_W = DATA_W - NUM_SRC;

  // Named internal events, visible to the bound checker.
  logic               flag_sel, en_sel, flag_wr, en_wr;
  logic [NUM_SRC-1:0] sw_clr;
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] en_q;

  irqf_decode #(
    .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .EN_ADDR(EN_ADDR)
  ) u_dec (
    .addr(bus_addr), .wr(bus_wr),
    .flag_sel(flag_sel), .en_sel(en_sel),
    .flag_wr(flag_wr), .en_wr(en_wr)
  );

  assign sw_clr = {NUM_SRC{flag_wr}} & bus_wdata[NUM_SRC-1:0];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    irqf_flag_cell u_cell (
      .clk(clk), .rst(rst),
      .set_evt(evt_pulse[i]), .clr_sw(sw_clr[i]), .clr_ack(irq_ack[i]),
      .q(flag_q[i])
    );
    assign irq_req[i] = req_gate(glb_ie, en_q[i], flag_q[i]);
  end

  irqf_enable_reg #(.NUM_SRC(NUM_SRC)) u_en (
    .clk(clk), .rst(rst), .we(en_wr),
    .wdata(bus_wdata[NUM_SRC-1:0]), .en(en_q)
  );

  irqf_read_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rd (
    .flag_sel(flag_sel), .en_sel(en_sel),
    .flags(flag_q), .en(en_q), .rdata(bus_rdata)
  );

  if (SPARE_W > 0) begin : g_spare
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];
  end
endmodule

// File: rtl/irq_flag_bank_chk.sv
module irq_flag_bank_chk #(
  parameter int unsigned NUM_SRC   = 3,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned FLAG_ADDR = 0,
  parameter int unsigned EN_ADDR   = 1
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [NUM_SRC-1:0] evt_pulse,
  input logic [NUM_SRC-1:0] irq_ack,
  input logic               glb_ie,
  input logic [NUM_SRC-1:0] irq_req,
  input logic [NUM_SRC-1:0] flag_q,
  input logic [NUM_SRC-1:0] en_q
);
  logic fw, ew;
  assign fw = bus_wr && (bus_addr == ADDR_W'(FLAG_ADDR));
  assign ew = bus_wr && (bus_addr == ADDR_W'(EN_ADDR));

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (flag_q == '0 && en_q == '0)); // R1

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ew |=> $stable(en_q)); // R8

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_a
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
      evt_pulse[i] |=> flag_q[i]); // R5

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (fw && bus_wdata[i] && !evt_pulse[i]) |=> !flag_q[i]); // R3

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (irq_ack[i] && !evt_pulse[i]) |=> !flag_q[i]); // R4

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!evt_pulse[i] && !irq_ack[i] && !(fw && bus_wdata[i])) |=> $stable(flag_q[i])); // R8

    AST_REQ_GATED: assert property (@(posedge clk) disable iff (rst)
      irq_req[i] |-> (glb_ie && en_q[i] && flag_q[i])); // R6
  end
endmodule

bind irq_flag_bank irq_flag_bank_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .FLAG_ADDR(FLAG_ADDR), .EN_ADDR(EN_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .evt_pulse(evt_pulse), .irq_ack(irq_ack),
  .glb_ie(glb_ie), .irq_req(irq_req), .flag_q(flag_q), .en_q(en_q)
);

// File: tb/irq_flag_bank_test.sv
module irq_flag_bank_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [2:0] evt_pulse;
  logic [2:0] irq_ack;
  logic       glb_ie;
  logic [2:0] irq_req;

  int checks = 0;
  int failures = 0;

  irq_flag_bank uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
    .irq_ack(irq_ack), .glb_ie(glb_ie), .irq_req(irq_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input logic [2:0] e, input logic [2:0] k);
    @(negedge clk);
    evt_pulse = e; irq_ack = k;
    @(negedge clk);
    evt_pulse = '0; irq_ack = '0;
  endtask

  task automatic load_flags(input logic [2:0] p);
    wr_reg(2'd0, 8'h07);
    if (p != 3'b000) pulse(p, 3'b000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] r, r2;
    rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    evt_pulse = '0; irq_ack = '0; glb_ie = 1'b1;
    repeat (3) @(negedge clk);
    // drive activity during reset: must not leave state behind (R1)
    evt_pulse = 3'b111; @(negedge clk); evt_pulse = '0;
    rst = 1'b0;
    rd_reg(2'd0, r); check("R1 flags after reset", r, 8'h00);
    rd_reg(2'd1, r); check("R1 enables after reset", r, 8'h00);
    #1 check("R1 irq after reset", {5'b0, irq_req}, 8'h00);

    // R2: every event pattern sets exactly its flags
    for (int p = 0; p < 8; p++) begin
      load_flags(3'(p));
      rd_reg(2'd0, r); check("R2 event sets flags", r, 8'(p));
    end

    // R3: every flag pattern against every write mask
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 8; m++) begin
        load_flags(3'(p));
        wr_reg(2'd0, 8'(m) | 8'hF8);
        rd_reg(2'd0, r);
        check("R3 write-one-to-clear", r, 8'(p & ~m & 7));
      end
    end

    // R4: every flag pattern against every acknowledge vector
    for (int p = 0; p < 8; p++) begin
      for (int a = 0; a < 8; a++) begin
        load_flags(3'(p));
        pulse(3'b000, 3'(a));
        rd_reg(2'd0, r);
        check("R4 ack clears", r, 8'(p & ~a & 7));
      end
    end

    // R5: set beats clear when both land in the same cycle
    for (int e = 0; e < 8; e++) begin
      load_flags(3'b111);
      @(negedge clk);
      bus_addr = 2'd0; bus_wr = 1'b1; bus_wdata = 8'h07;
      evt_pulse = 3'(e); irq_ack = 3'b111;
      @(negedge clk);
      bus_wr = 1'b0; evt_pulse = '0; irq_ack = '0;
      rd_reg(2'd0, r);
      check("R5 set wins over clear", r, 8'(e));
    end

    // R6: all flag x enable x global combinations
    for (int f = 0; f < 8; f++) begin
      for (int n = 0; n < 8; n++) begin
        for (int g = 0; g < 2; g++) begin
          load_flags(3'(f));
          wr_reg(2'd1, 8'(n));
          glb_ie = g[0];
          #1 check("R6 request gating", {5'b0, irq_req}, 8'(g != 0 ? (f & n) : 0));
        end
      end
    end
    glb_ie = 1'b1;

    // R7: enable read/write, upper bits zero, unmapped addresses zero
    for (int v = 0; v < 8; v++) begin
      wr_reg(2'd1, 8'hF8 | 8'(v));
      rd_reg(2'd1, r); check("R7 enable readback", r, 8'(v));
    end
    load_flags(3'b111);
    rd_reg(2'd0, r); check("R7 flag upper bits zero", r, 8'h07);
    rd_reg(2'd2, r); check("R7 unmapped addr 2", r, 8'h00);
    rd_reg(2'd3, r); check("R7 unmapped addr 3", r, 8'h00);

    // R8: register isolation and side-effect-free reads
    load_flags(3'b101);
    wr_reg(2'd1, 8'h03);
    wr_reg(2'd1, 8'h06);
    rd_reg(2'd0, r); check("R8 enable write leaves flags", r, 8'h05);
    wr_reg(2'd0, 8'h02);
    rd_reg(2'd1, r); check("R8 flag write leaves enables", r, 8'h06);
    wr_reg(2'd2, 8'hFF);
    wr_reg(2'd3, 8'hFF);
    rd_reg(2'd0, r); check("R8 unmapped write leaves flags", r, 8'h05);
    rd_reg(2'd1, r); check("R8 unmapped write leaves enables", r, 8'h06);
    rd_reg(2'd0, r);
    repeat (3) @(negedge clk);
    rd_reg(2'd0, r2); check("R8 read has no side effect", r2, r);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule